// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from up to `NUM_SRC` peripheral controllers and presents a single request line to the processor. Each source has an enable bit. Software loads all of these bits at once through a command-register write strobe. A global enable input follows the processor's interrupt-enable flag.

When the processor answers with an acknowledge, the block selects the highest-priority source that is eligible. It drives that source's vector-table byte offset onto an identification bus and takes the source into service. The offset is the source index times the vector stride.

The block keeps the level of the service routine currently running. While a level is in service, requests at that level or below wait in the pending register. A strictly higher-priority request can preempt the running routine, and the interrupted level is pushed onto a nesting stack. A return-from-interrupt strobe pops the stack. Any pending request that the popped level allows raises the request line in the very next cycle.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, no source is pending, all source enables are 0, no level is in service, `intr` is 0 and `id_bus` is 0. An enabled source whose request is high at a clock edge becomes pending, and it stays pending after the request drops.
- R2: A write on `en_wr` loads `en_wdata` as the per-source enable mask (bit i is source i). A request from a disabled source is not latched and never raises `intr`.
- R3: `intr` is 1 exactly when `gie` is 1 and at least one pending, enabled source is eligible. While `gie` is 0, `intr` stays 0 and pending bits are kept.
- R4: During any cycle with `inta` high and an eligible source, `id_bus` carries the winner index times `VEC_STRIDE` (4 by default: source n gives byte offset 4*n). In every other cycle `id_bus` is 0.
- R5: Source 0 has the highest priority. Among eligible sources, the one with the lowest index wins.
- R6: While source L is in service, sources with index L or above are not eligible. They do not raise `intr`, and they stay pending.
- R7: A source with an index below the level in service is eligible. Acknowledging it pushes the current level and makes the new source the level in service.
- R8: A return (`rti` high with a non-empty stack) restores the pushed level at the clock edge. In the following cycle, `intr` reflects the pending sources that the restored level allows.
- R9: `rti` with an empty stack has no effect.
- R10: An acknowledge clears the winner's pending bit, unless that source's request is still high at the same edge, in which case it stays pending.
- R11: When `inta` and `rti` are high in the same cycle, the winner is chosen against the level held before the return. The ended level is discarded, the winner becomes the level in service, and the stack depth does not change.
- R12: `inta` while no source is eligible drives `id_bus` to 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Level-sensitive request, one bit per source |
| en_wr | input | 1 | Command-register write strobe for the enable mask |
| en_wdata | input | NUM_SRC | New per-source enable mask |
| gie | input | 1 | Global interrupt enable from the processor |
| intr | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Interrupt acknowledge from the processor |
| rti | input | 1 | Return-from-interrupt strobe |
| id_bus | output | DATA_W | Vector byte offset of the acknowledged source |

## Verification
Two coincidences matter in this block. The first is an acknowledge that lands in the same cycle as a return-from-interrupt. The bench provokes it while a nested service is running and while a lower source waits pending. The reference model decides the winner against the pre-return level and expects the stack depth to stay unchanged. This shows up in the codes of the later acknowledges.

The second is a source that is acknowledged while its request is still held. The model expects that source to stay pending, so it comes back once the mask allows it. A randomized phase mixes both cases with arbitrary request, mask and return traffic, and it compares `intr` and `id_bus` against the model on every clock.

// File: rtl/vic_pkg.sv
package vic_pkg;

   // stack operation requested in one cycle
   typedef struct packed {
      logic push;
      logic pop;
   } stk_op_t;

   localparam int unsigned VIC_MAX_SRC = 32;

endpackage

// File: rtl/vic_pend_bank.sv
module vic_pend_bank #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] en,
   input  logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] pend
);

   // one latch cell per source; a held request re-arms over a clear
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[g] <= 1'b0;
         end else begin
            pend[g] <= (pend[g] & ~clr[g]) | (req[g] & en[g]);
         end
      end
   end

endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned LVL_W   = 4
) (
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] en,
   input  logic [LVL_W-1:0]   cur_lvl,
   output logic               any_elig,
   output logic [LVL_W-1:0]   win_idx
);

   logic [NUM_SRC-1:0] above;
   logic [NUM_SRC-1:0] elig;

   // a source is eligible only if strictly above the level in service
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
      assign above[g] = (LVL_W'(g) < cur_lvl);
   end

   assign elig     = pend & en & above;
   assign any_elig = |elig;

   // lowest index wins: scan downward so the last hit is the smallest
   always_comb begin
      win_idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i]) win_idx = LVL_W'(i);
      end
   end

endmodule

// File: rtl/vic_lvl_stack.sv
module vic_lvl_stack
   import vic_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned LVL_W = 4,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned SP_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stk_op_t          op,
   input  logic [LVL_W-1:0] din,
   output logic [LVL_W-1:0] top,
   output logic             empty,
   output logic [SP_W-1:0]  cnt
);

   logic [LVL_W-1:0] mem [DEPTH];
   logic [SP_W-1:0]  sp;
   logic             full;
   logic [AW-1:0]    wr_a;
   logic [AW-1:0]    rd_a;

   assign empty = (sp == '0);
   assign full  = (sp == SP_W'(DEPTH));
   assign wr_a  = AW'(sp);
   assign rd_a  = AW'(sp - 1'b1);
   assign top   = empty ? '0 : mem[rd_a];
   assign cnt   = sp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp <= '0;
      end else if (op.push && op.pop && !empty) begin
         sp <= sp;             // pop then push of the same top: no change
      end else if (op.push && !full) begin
         sp <= sp + 1'b1;
      end else if (op.pop && !empty) begin
         sp <= sp - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (op.push && !full && !(op.pop && !empty)) begin
         mem[wr_a] <= din;
      end
   end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 8,
   parameter int unsigned STK_DEPTH  = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned VEC_STRIDE = 4,
   localparam int unsigned LVL_W     = $clog2(NUM_SRC + 1),
   localparam int unsigned SP_W      = $clog2(STK_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               en_wr,
   input  logic [NUM_SRC-1:0] en_wdata,
   input  logic               gie,
   output logic               intr,
   input  logic               inta,
   input  logic               rti,
   output logic [DATA_W-1:0]  id_bus
);

   // elaboration-time parameter checks
   if (NUM_SRC < 2 || NUM_SRC > VIC_MAX_SRC) begin : g_bad_src
      $error("vec_irq_ctrl: NUM_SRC out of range");
   end
   if (STK_DEPTH < NUM_SRC) begin : g_bad_depth
      $error("vec_irq_ctrl: STK_DEPTH must cover every nesting level");
   end
   if ((NUM_SRC - 1) * VEC_STRIDE >= (1 << DATA_W)) begin : g_bad_width
      $error("vec_irq_ctrl: DATA_W too narrow for vector offsets");
   end

   localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NUM_SRC);

   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] clr;
   logic [LVL_W-1:0]   cur_lvl;
   logic [LVL_W-1:0]   win_idx;
   logic [LVL_W-1:0]   stk_top;
   logic [SP_W-1:0]    stk_cnt;
   logic               stk_empty;
   logic               any_elig;
   logic               take;
   logic               ret_ok;
   stk_op_t            sop;

   always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= '0;
      else if (en_wr) en_q <= en_wdata;
   end

   vic_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (irq_req),
      .en   (en_q),
      .clr  (clr),
      .pend (pend)
   );

   vic_prio_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_pick (
      .pend    (pend),
      .en      (en_q),
      .cur_lvl (cur_lvl),
      .any_elig(any_elig),
      .win_idx (win_idx)
   );

   assign take   = inta & any_elig;
   assign ret_ok = rti & ~stk_empty;
   assign sop    = '{push: take, pop: rti};
   assign clr    = take ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << win_idx) : '0;

   vic_lvl_stack #(.DEPTH(STK_DEPTH), .LVL_W(LVL_W)) u_stk (
      .clk  (clk),
      .rst_n(rst_n),
      .op   (sop),
      .din  (cur_lvl),
      .top  (stk_top),
      .empty(stk_empty),
      .cnt  (stk_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      cur_lvl <= LVL_IDLE;
      else if (take)   cur_lvl <= win_idx;
      else if (ret_ok) cur_lvl <= stk_top;
   end

   assign intr   = gie & any_elig;
   assign id_bus = take ? (DATA_W'(win_idx) * DATA_W'(VEC_STRIDE)) : '0;

endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
   parameter int unsigned STK_DEPTH  = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned VEC_STRIDE = 4,
   parameter int unsigned LVL_W      = 4,
   parameter int unsigned SP_W       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gie,
   input logic              inta,
   input logic              rti,
   input logic              intr,
   input logic [DATA_W-1:0] id_bus,
   input logic [LVL_W-1:0]  cur_lvl,
   input logic [SP_W-1:0]   stk_cnt,
   input logic              any_elig
);

   // R3
   gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !intr);

   // R4
   id_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inta |-> (id_bus == '0));

   // R4
   id_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_bus % DATA_W'(VEC_STRIDE)) == '0);

   // R7
   preempt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && any_elig) |=> (cur_lvl < $past(cur_lvl)));

   // R9
   empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rti && !inta && stk_cnt == '0) |=> $stable(cur_lvl) && (stk_cnt == '0));

   // R12
   idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && !any_elig && !rti) |=> $stable(cur_lvl) && $stable(stk_cnt));

   // R11
   ack_ret_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && any_elig && rti && stk_cnt != '0) |=> $stable(stk_cnt));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_cnt <= SP_W'(STK_DEPTH));

endmodule

bind vec_irq_ctrl vic_chk #(
   .STK_DEPTH (STK_DEPTH),
   .DATA_W    (DATA_W),
   .VEC_STRIDE(VEC_STRIDE),
   .LVL_W     (LVL_W),
   .SP_W      (SP_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .gie     (gie),
   .inta    (inta),
   .rti     (rti),
   .intr    (intr),
   .id_bus  (id_bus),
   .cur_lvl (cur_lvl),
   .stk_cnt (stk_cnt),
   .any_elig(any_elig)
);

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;

   localparam int N      = 8;
   localparam int DW     = 8;
   localparam int STRIDE = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  irq_req;
   logic          en_wr;
   logic [N-1:0]  en_wdata;
   logic          gie;
   logic          intr;
   logic          inta;
   logic          rti;
   logic [DW-1:0] id_bus;

   int n_chk  = 0;
   int n_fail = 0;
   string tag = "R1";

   // behavioural model state
   bit [N-1:0] m_pend;
   bit [N-1:0] m_en;
   int         m_lvl;
   int         m_stk[$];

   always #5 clk = ~clk;

   vec_irq_ctrl #(.NUM_SRC(N), .STK_DEPTH(8), .DATA_W(DW), .VEC_STRIDE(STRIDE)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_req (irq_req),
      .en_wr   (en_wr),
      .en_wdata(en_wdata),
      .gie     (gie),
      .intr    (intr),
      .inta    (inta),
      .rti     (rti),
      .id_bus  (id_bus)
   );

   function automatic int m_win();
      for (int i = 0; i < N; i++)
         if (m_pend[i] && m_en[i] && i < m_lvl) return i;
      return -1;
   endfunction

   task automatic check(string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // inputs already driven; compare, then advance model with the edge
   task automatic cyc();
      int w;
      bit tk, pk;
      int nl;
      bit [N-1:0] np;
      #1;
      w = m_win();
      check("intr", int'(intr), (gie && w >= 0) ? 1 : 0);
      check("id_bus", int'(id_bus), (inta && w >= 0) ? w * STRIDE : 0);
      tk = inta && (w >= 0);
      pk = rti && (m_stk.size() > 0);
      np = m_pend;
      nl = m_lvl;
      if (tk) begin
         np[w] = 1'b0;
         if (!pk) m_stk.push_back(m_lvl);
         nl = w;
      end else if (pk) begin
         nl = m_stk.pop_back();
      end
      np = np | (irq_req & m_en);
      @(posedge clk);
      m_pend = np;
      m_lvl  = nl;
      if (en_wr) m_en = en_wdata;
      @(negedge clk);
   endtask

   task automatic idle_in();
      irq_req = '0; en_wr = 0; en_wdata = '0; inta = 0; rti = 0;
   endtask

   task automatic ack();
      inta = 1; cyc(); inta = 0;
   endtask

   task automatic ret();
      rti = 1; cyc(); rti = 0;
   endtask

   task automatic pulse(bit [N-1:0] r);
      irq_req = r; cyc(); irq_req = '0;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle_in();
      gie = 1; rst_n = 0;
      m_pend = '0; m_en = '0; m_lvl = N;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      tag = "R1";                 // reset state
      cyc();

      tag = "R2";                 // disabled source ignored
      irq_req = 8'h08; cyc(); cyc(); irq_req = '0; cyc();
      en_wr = 1; en_wdata = 8'hFF; cyc(); en_wr = 0; cyc();

      tag = "R1";                 // latched after request drops
      pulse(8'h20); cyc(); cyc();
      tag = "R10"; ack(); cyc();
      tag = "R8"; ret(); cyc();

      tag = "R5";                 // two at once, lowest index wins
      pulse(8'h44); ack(); cyc();
      tag = "R6";                 // masked at/below level 2
      pulse(8'h10); cyc(); pulse(8'h04); cyc();
      tag = "R7";                 // preemption by source 1
      pulse(8'h02); ack(); cyc();
      tag = "R8"; ret(); cyc(); ack(); ret(); ret(); cyc(); ack(); cyc(); ret(); cyc();

      tag = "R9"; ret(); ret(); cyc();
      tag = "R12"; ack(); ack(); cyc();

      tag = "R3";                 // global enable off
      gie = 0; pulse(8'h80); cyc(); cyc(); gie = 1; cyc(); ack(); ret(); cyc();

      tag = "R11";                // ack and return together
      pulse(8'h08); ack(); pulse(8'h01); cyc(); pulse(8'h20);
      inta = 1; rti = 1; cyc(); inta = 0; rti = 0;
      ack(); ret(); ret(); cyc(); ack(); ret(); ret(); cyc();

      tag = "R10";                // ack while request held
      irq_req = 8'h10; ack(); cyc(); irq_req = '0; ret(); cyc(); ack(); ret(); cyc();

      tag = "R4";                 // mixed traffic
      for (int k = 0; k < 2000; k++) begin
         irq_req  = N'($urandom) & N'($urandom);
         en_wr    = ($urandom % 16) == 0;
         en_wdata = N'($urandom) | N'($urandom);
         gie      = ($urandom % 8) != 0;
         inta     = ($urandom % 3) == 0;
         rti      = ($urandom % 4) == 0;
         cyc();
      end
      idle_in();
      cyc();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule